// File: doc/BRIEF.md
# Fixed-Point Second-Order ODE Stepper

This block integrates the equation y'' + 3·z·y' + 3·y = 0 by forward stepping in signed fixed point. A caller presents a start point z, the values y and u (the first derivative of y), a step width dz and a stop bound a, then pulses `start`. Each pass of the loop advances z by dz and updates y and u from the values of the previous pass. The loop repeats while the new z stays below the bound. The final y, u and z are then returned together with a one-cycle `done` pulse.

Internally a small controller steps through a fixed list of control steps. The list assigns each multiplication, the addition, the two subtractions and the comparison to a clock cycle after all of its operands exist. Intermediate products wait in temporary registers between steps. The parameter `NUM_MULT` sets how many multiplier units the schedule may use. With four units a pass takes four cycles. With one shared unit it takes seven cycles and less area.

Top module: `diffeq_solver`

## Requirements
- R1: Values are two's-complement with FRAC fraction bits in W bits. A product is the full signed product shifted right arithmetically by FRAC and cut to W bits. Sums and differences wrap modulo 2^W. The constant three is 3·2^FRAC.
- R2: One pass computes z1 = z + dz, y1 = y + (u·dz), and u1 = (u − (3·z)·(u·dz)) − (3·y)·dz, with the products grouped exactly as written. z, y and u are replaced together only after all three are ready.
- R3: The loop repeats while z1 < a, signed. The outputs after the last pass equal a bit-exact model of R1 and R2.
- R4: With `start` sampled at clock edge E and N passes, `done` is high in the cycle after edge E + N·S. S is 4 when NUM_MULT is 4 and 7 when NUM_MULT is 1.
- R5: If z_in ≥ a_in when `start` is sampled, no pass runs. `busy` stays low, `done` is high in the cycle after that edge, and the outputs equal z_in, y_in and u_in.
- R6: `done` lasts exactly one cycle.
- R7: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` rises. It is never high together with `done`.
- R8: `start` while `busy` is high is ignored. The result and the latency are those of the run already in progress.
- R9: The outputs hold their values from `done` until the next accepted `start`.
- R10: After reset, `busy` and `done` are low and the three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a solve with the presented values |
| z_in | input | W | Initial independent variable |
| y_in | input | W | Initial y |
| u_in | input | W | Initial y' |
| dz_in | input | W | Step width |
| a_in | input | W | Stop bound for z |
| busy | output | 1 | A solve is in progress |
| done | output | 1 | One-cycle completion pulse |
| z_out | output | W | Final z |
| y_out | output | W | Final y |
| u_out | output | W | Final y' |

## Verification
The assertions assume that `start` is a level the caller may hold or repeat at any time. They do not assume a clean pulse, so the hold and pulse properties are written to tolerate `start` arriving while `busy` is high. The assertions also take for granted that the loop ends: a positive dz and a reachable bound. The stimulus therefore uses only positive step widths and bounds a small number of steps away. This keeps every run short enough that the wrap rules of R1 are exercised only through ordinary small products. Extra `start` pulses with different data are injected mid-run to test that property.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;

    localparam int MAX_MULT = 4;

    typedef enum logic [2:0] {
        MUL_NONE = 3'd0,
        MUL_3Z,
        MUL_3Y,
        MUL_UDZ,
        MUL_P3DZ,
        MUL_P1P2
    } mul_op_e;

    typedef enum logic [1:0] {
        ADD_NONE = 2'd0,
        ADD_Z,
        ADD_Y
    } add_op_e;

    typedef enum logic [1:0] {
        SUB_NONE = 2'd0,
        SUB_HEAD,
        SUB_TAIL
    } sub_op_e;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_RUN  = 1'b1
    } ctrl_state_e;

    // Operations issued in one control step.
    typedef struct packed {
        mul_op_e [MAX_MULT-1:0] mop;
        add_op_e                add;
        logic                   cmp;
        sub_op_e                sub;
    } step_ctl_t;

    function automatic int steps_per_iter(input int n_mult);
        return (n_mult >= MAX_MULT) ? 4 : 7;
    endfunction

    // Static schedule: every operation sits after its operands.
    function automatic step_ctl_t schedule_lookup(input int n_mult, input int step);
        step_ctl_t c;
        c = '0;
        if (n_mult >= MAX_MULT) begin
            case (step)
                0: begin
                    c.mop[0] = MUL_3Z;
                    c.mop[1] = MUL_UDZ;
                    c.mop[2] = MUL_3Y;
                    c.add    = ADD_Z;
                end
                1: begin
                    c.mop[0] = MUL_P1P2;
                    c.mop[1] = MUL_P3DZ;
                    c.add    = ADD_Y;
                    c.cmp    = 1'b1;
                end
                2: c.sub = SUB_HEAD;
                3: c.sub = SUB_TAIL;
                default: ;
            endcase
        end else begin
            case (step)
                0: begin
                    c.mop[0] = MUL_3Z;
                    c.add    = ADD_Z;
                end
                1: begin
                    c.mop[0] = MUL_3Y;
                    c.cmp    = 1'b1;
                end
                2: c.mop[0] = MUL_UDZ;
                3: begin
                    c.mop[0] = MUL_P3DZ;
                    c.add    = ADD_Y;
                end
                4: c.mop[0] = MUL_P1P2;
                5: c.sub = SUB_HEAD;
                6: c.sub = SUB_TAIL;
                default: ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/diffeq_fxmul.sv
module diffeq_fxmul #(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] full;

    assign full = a * b;
    assign p    = W'(full >>> FRAC);

endmodule

// File: rtl/diffeq_ctrl.sv
module diffeq_ctrl
    import diffeq_pkg::*;
#(
    parameter int NUM_MULT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      less,
    input  logic      lt_q,
    output logic      busy,
    output logic      done,
    output logic      load,
    output logic      commit,
    output step_ctl_t ctl
);
    localparam int STEPS = steps_per_iter(NUM_MULT);
    localparam int SW    = $clog2(STEPS);

    ctrl_state_e   state_q;
    logic [SW-1:0] step_q;
    logic          done_q;
    logic          last;

    assign busy   = (state_q == CS_RUN);
    assign load   = start && (state_q == CS_IDLE);
    assign last   = (state_q == CS_RUN) && (step_q == SW'(STEPS - 1));
    assign commit = last;
    assign done   = done_q;

    always_comb begin
        if (state_q == CS_RUN) ctl = schedule_lookup(NUM_MULT, int'(step_q));
        else                   ctl = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CS_IDLE: begin
                    if (start) begin
                        step_q <= '0;
                        if (less) state_q <= CS_RUN;
                        else      done_q  <= 1'b1;
                    end
                end
                CS_RUN: begin
                    if (last) begin
                        step_q <= '0;
                        if (!lt_q) begin
                            state_q <= CS_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/diffeq_dpath.sv
module diffeq_dpath
    import diffeq_pkg::*;
#(
    parameter int W        = 16,
    parameter int FRAC     = 8,
    parameter int NUM_MULT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                commit,
    input  step_ctl_t           ctl,
    input  logic signed [W-1:0] z_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] dz_in,
    input  logic signed [W-1:0] a_in,
    output logic signed [W-1:0] z_q,
    output logic signed [W-1:0] y_q,
    output logic signed [W-1:0] u_q,
    output logic                less,
    output logic                lt_q
);
    localparam int NU = (NUM_MULT >= MAX_MULT) ? MAX_MULT : 1;
    localparam logic signed [W-1:0] THREE = W'(3 << FRAC);

    logic signed [W-1:0] dz_q, a_q, z1_q, y1_q, s_q;
    logic signed [W-1:0] p1_q, p2_q, p3_q, p4_q, p5_q;
    logic signed [W-1:0] ma [NU];
    logic signed [W-1:0] mb [NU];
    logic signed [W-1:0] mp [NU];
    logic signed [W-1:0] add_a, add_b, add_r;
    logic signed [W-1:0] sub_a, sub_b, sub_r;
    logic signed [W-1:0] cmp_a, cmp_b;

    // Multiplier units with operand steering.
    for (genvar i = 0; i < NU; i++) begin : g_mul
        always_comb begin
            case (ctl.mop[i])
                MUL_3Z:   begin ma[i] = THREE; mb[i] = z_q;  end
                MUL_3Y:   begin ma[i] = THREE; mb[i] = y_q;  end
                MUL_UDZ:  begin ma[i] = u_q;   mb[i] = dz_q; end
                MUL_P3DZ: begin ma[i] = p3_q;  mb[i] = dz_q; end
                MUL_P1P2: begin ma[i] = p1_q;  mb[i] = p2_q; end
                default:  begin ma[i] = '0;    mb[i] = '0;   end
            endcase
        end
        diffeq_fxmul #(.W(W), .FRAC(FRAC)) u_mul (
            .a(ma[i]),
            .b(mb[i]),
            .p(mp[i])
        );
    end

    // Single adder.
    always_comb begin
        case (ctl.add)
            ADD_Z:   begin add_a = z_q; add_b = dz_q; end
            ADD_Y:   begin add_a = y_q; add_b = p2_q; end
            default: begin add_a = '0;  add_b = '0;   end
        endcase
        add_r = add_a + add_b;
    end

    // Single subtractor.
    always_comb begin
        case (ctl.sub)
            SUB_HEAD: begin sub_a = u_q; sub_b = p4_q; end
            SUB_TAIL: begin sub_a = s_q; sub_b = p5_q; end
            default:  begin sub_a = '0;  sub_b = '0;   end
        endcase
        sub_r = sub_a - sub_b;
    end

    // Single comparator: entry check while idle, loop check in step.
    assign cmp_a = ctl.cmp ? z1_q : z_in;
    assign cmp_b = ctl.cmp ? a_q  : a_in;
    assign less  = (cmp_a < cmp_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q  <= '0; y_q  <= '0; u_q  <= '0;
            dz_q <= '0; a_q  <= '0;
            z1_q <= '0; y1_q <= '0; s_q  <= '0;
            p1_q <= '0; p2_q <= '0; p3_q <= '0; p4_q <= '0; p5_q <= '0;
            lt_q <= 1'b0;
        end else begin
            if (load) begin
                z_q  <= z_in;
                y_q  <= y_in;
                u_q  <= u_in;
                dz_q <= dz_in;
                a_q  <= a_in;
            end
            for (int i = 0; i < NU; i++) begin
                case (ctl.mop[i])
                    MUL_3Z:   p1_q <= mp[i];
                    MUL_UDZ:  p2_q <= mp[i];
                    MUL_3Y:   p3_q <= mp[i];
                    MUL_P1P2: p4_q <= mp[i];
                    MUL_P3DZ: p5_q <= mp[i];
                    default: ;
                endcase
            end
            if (ctl.add == ADD_Z) z1_q <= add_r;
            if (ctl.add == ADD_Y) y1_q <= add_r;
            if (ctl.cmp)          lt_q <= less;
            if (ctl.sub == SUB_HEAD) s_q <= sub_r;
            if (commit) begin
                z_q <= z1_q;
                y_q <= y1_q;
                u_q <= sub_r;
            end
        end
    end

endmodule

// File: rtl/diffeq_solver.sv
module diffeq_solver
    import diffeq_pkg::*;
#(
    parameter int W        = 16,
    parameter int FRAC     = 8,
    parameter int NUM_MULT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic signed [W-1:0] z_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] u_in,
    input  logic signed [W-1:0] dz_in,
    input  logic signed [W-1:0] a_in,
    output logic                busy,
    output logic                done,
    output logic signed [W-1:0] z_out,
    output logic signed [W-1:0] y_out,
    output logic signed [W-1:0] u_out
);
    step_ctl_t ctl;
    logic      load, commit, less, lt_q;

    diffeq_ctrl #(.NUM_MULT(NUM_MULT)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .less  (less),
        .lt_q  (lt_q),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .commit(commit),
        .ctl   (ctl)
    );

    diffeq_dpath #(.W(W), .FRAC(FRAC), .NUM_MULT(NUM_MULT)) u_dpath (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .commit(commit),
        .ctl   (ctl),
        .z_in  (z_in),
        .y_in  (y_in),
        .u_in  (u_in),
        .dz_in (dz_in),
        .a_in  (a_in),
        .z_q   (z_out),
        .y_q   (y_out),
        .u_q   (u_out),
        .less  (less),
        .lt_q  (lt_q)
    );

endmodule

// File: rtl/diffeq_solver_chk.sv
module diffeq_solver_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] z_out,
    input logic [W-1:0] y_out,
    input logic [W-1:0] u_out
);
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    assert_start_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy || done));

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy || start));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(z_out) && $stable(y_out) && $stable(u_out)));

endmodule

bind diffeq_solver diffeq_solver_chk #(.W(W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .done (done),
    .z_out(z_out),
    .y_out(y_out),
    .u_out(u_out)
);

// File: tb/diffeq_solver_bench.sv
module diffeq_solver_bench;
    localparam int W    = 16;
    localparam int FRAC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [W-1:0] z_in = '0, y_in = '0, u_in = '0, dz_in = '0, a_in = '0;

    logic busy4, done4, busy1, done1;
    logic signed [W-1:0] z4, y4, u4, z1, y1, u1;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    diffeq_solver #(.W(W), .FRAC(FRAC), .NUM_MULT(4)) u_diffeq_solver (
        .clk(clk), .rst(rst), .start(start),
        .z_in(z_in), .y_in(y_in), .u_in(u_in), .dz_in(dz_in), .a_in(a_in),
        .busy(busy4), .done(done4), .z_out(z4), .y_out(y4), .u_out(u4)
    );

    diffeq_solver #(.W(W), .FRAC(FRAC), .NUM_MULT(1)) u_diffeq_solver_1m (
        .clk(clk), .rst(rst), .start(start),
        .z_in(z_in), .y_in(y_in), .u_in(u_in), .dz_in(dz_in), .a_in(a_in),
        .busy(busy1), .done(done1), .z_out(z1), .y_out(y1), .u_out(u1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [W-1:0] m_mul(input logic signed [W-1:0] a,
                                                  input logic signed [W-1:0] b);
        longint p;
        p = longint'(a) * longint'(b);
        p = p >>> FRAC;
        return p[W-1:0];
    endfunction

    // Bit-exact reference for R1..R3
    task automatic model(input logic signed [W-1:0] z0, y0, u0, dz, a,
                         output logic signed [W-1:0] zf, yf, uf, output int n);
        logic signed [W-1:0] k3, zn, yn, un;
        k3 = W'(3 * (1 << FRAC));
        zf = z0; yf = y0; uf = u0; n = 0;
        while ((zf < a) && (n < 1000)) begin
            zn = zf + dz;
            yn = yf + m_mul(uf, dz);
            un = uf - m_mul(m_mul(k3, zf), m_mul(uf, dz));
            un = un - m_mul(m_mul(k3, yf), dz);
            zf = zn; yf = yn; uf = un; n++;
        end
    endtask

    task automatic run_case(input logic signed [W-1:0] z0, y0, u0, dz, a,
                            input bit poke);
        logic signed [W-1:0] ez, ey, eu;
        int n, lat4, lat1, lim;
        bit seen4, seen1;
        model(z0, y0, u0, dz, a, ez, ey, eu, n);
        lim = n * 7 + 12;
        seen4 = 0; seen1 = 0; lat4 = -1; lat1 = -1;
        @(negedge clk);
        z_in = z0; y_in = y0; u_in = u0; dz_in = dz; a_in = a; start = 1'b1;
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = 1'b0;
                if (n == 0) begin
                    check(busy4 == 0 && busy1 == 0, "R5", "busy on empty run", busy4 + busy1, 0);
                end else begin
                    check(busy4 == 1 && busy1 == 1, "R7", "busy after start", busy4 + busy1, 2);
                end
            end
            if (poke && c == 3) begin
                z_in = 16'sh7000; y_in = 16'sh1234; u_in = -16'sh0400;
                dz_in = 16'sh0001; a_in = -16'sh7000; start = 1'b1;
            end
            if (poke && c == 4) start = 1'b0;
            if (!seen4 && done4) begin seen4 = 1; lat4 = c; end
            if (!seen1 && done1) begin seen1 = 1; lat1 = c; end
            if (seen4 && seen1) break;
        end
        check(lat4 == n * 4 + 1, "R4", "latency NUM_MULT=4", lat4, n * 4 + 1);
        check(lat1 == n * 7 + 1, "R4", "latency NUM_MULT=1", lat1, n * 7 + 1);
        @(negedge clk);
        @(negedge clk);
        check(done4 == 0 && done1 == 0, "R6", "done width", done4 + done1, 0);
        check(busy4 == 0 && busy1 == 0, "R7", "busy after done", busy4 + busy1, 0);
        check(z4 == ez, "R3", "z 4-mult", z4, ez);
        check(y4 == ey, "R2", "y 4-mult", y4, ey);
        check(u4 == eu, "R1", "u 4-mult", u4, eu);
        check(z1 == ez, "R3", "z 1-mult", z1, ez);
        check(y1 == ey, "R2", "y 1-mult", y1, ey);
        check(u1 == eu, "R1", "u 1-mult", u1, eu);
        if (poke) check(lat4 == n * 4 + 1 && z4 == ez, "R8", "start ignored while busy", z4, ez);
        if (n == 0) check(z4 == z0 && y4 == y0 && u4 == u0, "R5", "outputs unchanged", u4, u0);
        repeat (3) @(negedge clk);
        check(z4 == ez && y4 == ey && u4 == eu && z1 == ez && u1 == eu, "R9", "hold", u1, eu);
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic signed [W-1:0] dzs [3];
        logic signed [W-1:0] zs  [3];
        logic signed [W-1:0] ys  [3];
        logic signed [W-1:0] us  [3];
        dzs = '{16'sh0020, 16'sh0040, 16'sh0100};
        zs  = '{-16'sh0100, 16'sh0000, 16'sh0080};
        ys  = '{16'sh0100, 16'sh0080, -16'sh0200};
        us  = '{16'sh0000, -16'sh0040, 16'sh0100};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy4 == 0 && done4 == 0 && busy1 == 0 && done1 == 0, "R10", "control after reset",
              busy4 + done4 + busy1 + done1, 0);
        check(z4 == 0 && y4 == 0 && u4 == 0 && z1 == 0 && y1 == 0 && u1 == 0, "R10",
              "outputs after reset", z4, 0);

        for (int d = 0; d < 3; d++)
            for (int zi = 0; zi < 3; zi++)
                for (int v = 0; v < 3; v++)
                    run_case(zs[zi], ys[v], us[v], dzs[d], 16'sh0100, (v == 1));

        // Boundaries
        run_case(16'sh0100, 16'sh0100, 16'sh0040, 16'sh0040, 16'sh0100, 0); // z == a
        run_case(16'sh0200, -16'sh0080, 16'sh0010, 16'sh0040, 16'sh0100, 0); // z > a
        run_case(16'sh00C0, 16'sh0100, 16'sh0080, 16'sh0040, 16'sh0100, 1); // one pass
        run_case(-16'sh0300, 16'sh0040, -16'sh0020, 16'sh0080, -16'sh0100, 1); // negative bound
        run_case(16'sh00FF, 16'sh0300, 16'sh0200, 16'sh0001, 16'sh0100, 0); // tiny step

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule